// File: doc/BRIEF.md
# Spatial Dither Unit

This block narrows a streamed RGB pixel from 10 bits per channel to either 6 or 8 bits per channel. Before the low bits are cut off, it adds a small pseudo-random value to each channel. This spreads the quantisation error across the picture, so the eye does not see flat bands. The random values come from 28-bit linear feedback shift registers. These can share one polynomial or use a separate polynomial per channel. They can be reloaded with a programmed seed at each frame or left to run freely. An optional high-pass step shapes the noise.

The block sits in a display output pipe, after colour processing and before the link encoder. Configuration inputs are expected to be static while a frame is streaming. One pixel enters per cycle when `in_valid` is high. The reduced pixel leaves one cycle later with `out_valid`.

Top module: `spatial_dither`

## Requirements
- R1: With `cfg_depth`=0 each output channel carries 6 bits in bits [5:0] and bits [7:6] are zero. With `cfg_depth`=1 each output channel carries 8 bits.
- R2: With `cfg_en`=0 each output channel equals the input channel shifted right by 4 (6-bit depth) or by 2 (8-bit depth).
- R3: With `cfg_en`=1 a noise word is added to the input channel before the shift. The noise word is the low 4 generator bits at 6-bit depth and the low 2 bits at 8-bit depth. The sum saturates at 1023.
- R4: A generator steps as `s <= {s[26:0], s[27] ^ s[t-1]}`, where t is its tap. It steps once per valid pixel and holds when `in_valid` is low.
- R5: With `cfg_mode`=0 all three channels take noise from the red generator, tap 3 (x^28+x^3+1). With `cfg_mode`=1 red uses tap 3, green uses tap 9 and blue uses tap 13, each from its own register.
- R6: All generators hold 1 after reset. A `frame_start` loads `cfg_seed`, and the pixel in that cycle already uses the seed. This load happens on every frame start when `cfg_frame_reseed`=1, and on the first frame start after reset in any case. A seed of zero is loaded as 1.
- R7: With `cfg_frame_reseed`=0, frame starts after the first one do not reload the generators, and the sequence continues.
- R8: With `cfg_hpf`=1 the 4-bit noise becomes (current - previous) >> 1, or 0 if the difference is negative. The previous sample is the unfiltered noise of the preceding valid pixel. At 8-bit depth the result is then masked to its low 2 bits.
- R9: A valid pixel with `line_start` high treats the previous sample as 0.
- R10: Outputs are registered with one cycle of latency. `out_valid` follows `in_valid` by one cycle, and the output channels hold their values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Red input |
| in_g | input | 10 | Green input |
| in_b | input | 10 | Blue input |
| frame_start | input | 1 | First pixel of a frame |
| line_start | input | 1 | First pixel of a line |
| cfg_en | input | 1 | Dither enable |
| cfg_depth | input | 1 | 0: 6-bit output, 1: 8-bit output |
| cfg_seed | input | 28 | Generator seed |
| cfg_mode | input | 1 | 0: shared polynomial, 1: per-channel polynomials |
| cfg_frame_reseed | input | 1 | Reload seed at every frame start |
| cfg_hpf | input | 1 | High-pass filter on noise |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |

## Verification
Suppose a generator holds a wrong value, steps on an idle cycle, or misses a seed load. Then the noise added to the next valid pixel changes, and an input chosen near a rounding boundary flips the output LSB one cycle later. The bench places inputs at such boundaries and compares every pixel against an independent reference model of the generators. A broken previous-sample register shows up on the second pixel of a line with the filter on. A wrong reload shows up as two reseeded frames that no longer match.

// File: rtl/spatial_dither.sv
module spatial_dither #(
  parameter int IN_W   = 10,
  parameter int HI_W   = 8,
  parameter int LO_W   = 6,
  parameter int LFSR_W = 28,
  parameter int TAP_R  = 3,
  parameter int TAP_G  = 9,
  parameter int TAP_B  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_r,
  input  logic [IN_W-1:0]   in_g,
  input  logic [IN_W-1:0]   in_b,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              cfg_en,
  input  logic              cfg_depth,
  input  logic [LFSR_W-1:0] cfg_seed,
  input  logic              cfg_mode,
  input  logic              cfg_frame_reseed,
  input  logic              cfg_hpf,
  output logic              out_valid,
  output logic [HI_W-1:0]   out_r,
  output logic [HI_W-1:0]   out_g,
  output logic [HI_W-1:0]   out_b
);
  localparam int DL = IN_W - LO_W;
  localparam int DH = IN_W - HI_W;
  localparam logic [IN_W-1:0] MAXV = '1;
  localparam logic [DL-1:0] HMASK = DL'((1 << DH) - 1);

  logic seeded;
  logic load;
  logic [LFSR_W-1:0] seed_nz;
  logic [IN_W-1:0] pin [3];
  logic [DL-1:0]   raw [3];
  logic [HI_W-1:0] res [3];

  assign load    = frame_start && (cfg_frame_reseed || !seeded);
  assign seed_nz = (cfg_seed == '0) ? LFSR_W'(1) : cfg_seed;
  assign pin[0]  = in_r;
  assign pin[1]  = in_g;
  assign pin[2]  = in_b;

  always_ff @(posedge clk) begin
    if (!rst_n) seeded <= 1'b0;
    else if (frame_start) seeded <= 1'b1;
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    localparam int TAP = (c == 0) ? TAP_R : ((c == 1) ? TAP_G : TAP_B);
    logic [LFSR_W-1:0] st, cur;
    logic [DL-1:0] prev, pv, src, hp, n4, nz;
    logic [DL:0] d;
    logic [IN_W:0] sum;
    logic [IN_W-1:0] sat, sh;

    assign cur    = load ? seed_nz : st;
    assign raw[c] = cur[DL-1:0];
    assign src    = cfg_mode ? raw[c] : raw[0];
    assign pv     = line_start ? '0 : prev;
    assign d      = {1'b0, src} - {1'b0, pv};
    assign hp     = d[DL] ? '0 : (d[DL-1:0] >> 1);
    assign n4     = cfg_hpf ? hp : src;
    assign nz     = cfg_depth ? (n4 & HMASK) : n4;
    assign sum    = {1'b0, pin[c]} + (cfg_en ? (IN_W+1)'(nz) : '0);
    assign sat    = sum[IN_W] ? MAXV : sum[IN_W-1:0];
    assign sh     = cfg_depth ? (sat >> DH) : (sat >> DL);
    assign res[c] = HI_W'(sh);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st   <= LFSR_W'(1);
        prev <= '0;
      end else if (in_valid) begin
        st   <= {cur[LFSR_W-2:0], cur[LFSR_W-1] ^ cur[TAP-1]};
        prev <= src;
      end else begin
        st   <= cur;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r <= '0;
      out_g <= '0;
      out_b <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_r <= res[0];
        out_g <= res[1];
        out_b <= res[2];
      end
    end
  end
endmodule

// File: rtl/spatial_dither_chk.sv
module spatial_dither_chk #(
  parameter int IN_W = 10,
  parameter int HI_W = 8,
  parameter int LO_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [IN_W-1:0] in_r,
  input logic            cfg_en,
  input logic            cfg_depth,
  input logic            out_valid,
  input logic [HI_W-1:0] out_r
);
  localparam int DH = IN_W - HI_W;

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_r));
  // R1
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_depth) |=> (out_r[HI_W-1:LO_W] == '0));
  // R2
  plain_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_en && cfg_depth) |=> (out_r == HI_W'($past(in_r) >> DH)));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_en && cfg_depth) |=> (out_r >= HI_W'($past(in_r) >> DH)));
  // R3
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_en && cfg_depth && (in_r == '1)) |=> (out_r == '1));
endmodule

bind spatial_dither spatial_dither_chk #(.IN_W(IN_W), .HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_r(in_r),
  .cfg_en(cfg_en), .cfg_depth(cfg_depth), .out_valid(out_valid), .out_r(out_r)
);

// File: tb/spatial_dither_test.sv
module spatial_dither_test;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [9:0] in_r = 0, in_g = 0, in_b = 0;
  logic frame_start = 0, line_start = 0;
  logic cfg_en = 0, cfg_depth = 0, cfg_mode = 0, cfg_frame_reseed = 0, cfg_hpf = 0;
  logic [27:0] cfg_seed = 0;
  logic out_valid;
  logic [7:0] out_r, out_g, out_b;

  int errors = 0;
  int checks = 0;

  logic [27:0] m_st [3];
  logic [3:0]  m_prev [3];
  bit          m_seeded;
  logic [7:0]  frame_a [8][3];

  always #2.5 clk = ~clk;

  spatial_dither uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .frame_start(frame_start), .line_start(line_start), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
    .cfg_seed(cfg_seed), .cfg_mode(cfg_mode), .cfg_frame_reseed(cfg_frame_reseed),
    .cfg_hpf(cfg_hpf), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // {depth, r, g, b, exp_r, exp_g, exp_b} with dithering off
  localparam logic [54:0] VEC [4] = '{
    {1'b1, 10'h3FF, 10'h155, 10'h000, 8'hFF, 8'h55, 8'h00},
    {1'b0, 10'h3FF, 10'h155, 10'h00F, 8'h3F, 8'h15, 8'h00},
    {1'b1, 10'h201, 10'h0FE, 10'h3FC, 8'h80, 8'h3F, 8'hFF},
    {1'b0, 10'h200, 10'h0F0, 10'h3EF, 8'h20, 8'h0F, 8'h3E}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] stepf(input logic [27:0] s, input int tap);
    return {s[26:0], s[27] ^ s[tap-1]};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_st[c] = 28'd1;
      m_prev[c] = 4'd0;
    end
    m_seeded = 0;
  endtask

  // drive one pixel at a negedge, check output at the next negedge (R3 R4 R5 R6 R7 R8 R9)
  task automatic px(input bit fs, input bit ls, input logic [9:0] r, input logic [9:0] g,
                    input logic [9:0] b, input string req, output logic [7:0] got [3]);
    logic [9:0] pin [3];
    logic [27:0] cur [3];
    logic [7:0] exp [3];
    logic [27:0] snz;
    bit ld;
    int taps [3];
    taps = '{3, 9, 13};
    pin = '{r, g, b};
    snz = (cfg_seed == 0) ? 28'd1 : cfg_seed;
    ld = fs && (cfg_frame_reseed || !m_seeded);
    for (int c = 0; c < 3; c++) cur[c] = ld ? snz : m_st[c];
    for (int c = 0; c < 3; c++) begin
      logic [3:0] src, pv, n;
      int sum;
      src = cfg_mode ? cur[c][3:0] : cur[0][3:0];
      pv = ls ? 4'd0 : m_prev[c];
      n = cfg_hpf ? ((src >= pv) ? 4'((src - pv) >> 1) : 4'd0) : src;
      if (cfg_depth) n = n & 4'd3;
      sum = int'(pin[c]) + (cfg_en ? int'(n) : 0);
      if (sum > 1023) sum = 1023;
      exp[c] = cfg_depth ? 8'(sum >> 2) : 8'(sum >> 4);
      m_prev[c] = src;
    end
    for (int c = 0; c < 3; c++) m_st[c] = stepf(cur[c], taps[c]);
    if (fs) m_seeded = 1;
    in_valid = 1; frame_start = fs; line_start = ls;
    in_r = r; in_g = g; in_b = b;
    @(negedge clk);
    got = '{out_r, out_g, out_b};
    chk(out_valid == 1'b1, {req, " valid"}, 32'(out_valid), 1);
    chk(out_r == exp[0], {req, " red"}, 32'(out_r), 32'(exp[0]));
    chk(out_g == exp[1], {req, " green"}, 32'(out_g), 32'(exp[1]));
    chk(out_b == exp[2], {req, " blue"}, 32'(out_b), 32'(exp[2]));
    frame_start = 0; line_start = 0;
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got [3];
    model_reset();
    repeat (3) @(negedge clk);
    // reset state R10
    chk(out_valid == 0 && out_r == 0 && out_g == 0 && out_b == 0, "R10 reset", 32'(out_r), 0);
    rst_n = 1;
    @(negedge clk);

    // table: plain truncation R1 R2
    for (int i = 0; i < 4; i++) begin
      cfg_depth = VEC[i][54];
      in_valid = 1;
      in_r = VEC[i][53:44]; in_g = VEC[i][43:34]; in_b = VEC[i][33:24];
      @(negedge clk);
      chk(out_r == VEC[i][23:16], "R2 trunc red", 32'(out_r), 32'(VEC[i][23:16]));
      chk(out_g == VEC[i][15:8], "R1 depth green", 32'(out_g), 32'(VEC[i][15:8]));
      chk(out_b == VEC[i][7:0], "R2 trunc blue", 32'(out_b), 32'(VEC[i][7:0]));
    end
    idle(2);
    chk(out_valid == 0, "R10 valid low", 32'(out_valid), 0);

    // hand-computed: seed 1, shared mode, 6-bit R3 R4 R6
    cfg_en = 1; cfg_depth = 0; cfg_mode = 0; cfg_seed = 28'd1; cfg_frame_reseed = 0;
    px(1, 1, 10'd15, 10'd14, 10'd0, "R6 seed", got);
    chk(got[0] == 8'd1 && got[1] == 8'd0, "R3 noise 1", 32'(got[0]), 1);
    px(0, 0, 10'd14, 10'd13, 10'd0, "R4 step", got);
    chk(got[0] == 8'd1 && got[1] == 8'd0, "R4 noise 2", 32'(got[0]), 1);
    idle(3);
    chk(out_r == 8'd1, "R10 hold", 32'(out_r), 1);
    px(0, 0, 10'd12, 10'd11, 10'd0, "R4 hold no step", got);
    chk(got[0] == 8'd1 && got[1] == 8'd0, "R4 noise 4", 32'(got[0]), 1);

    // per-channel polynomials, 8-bit R5
    cfg_mode = 1; cfg_depth = 1; cfg_seed = 28'h9A5C3E1;
    for (int i = 0; i < 24; i++)
      px(i == 0, i % 6 == 0, 10'((i * 37 + 5) % 1024), 10'((i * 53 + 2) % 1024),
         10'((i * 71 + 3) % 1024), "R5 mode1", got);
    // shared mode, 6-bit R5
    cfg_mode = 0; cfg_depth = 0;
    for (int i = 0; i < 12; i++)
      px(0, 0, 10'((i * 29 + 7) % 1024), 10'((i * 13 + 1) % 1024), 10'((i * 41) % 1024), "R5 mode0", got);

    // high-pass with line starts R8 R9
    cfg_hpf = 1; cfg_mode = 1;
    for (int i = 0; i < 16; i++)
      px(0, i % 4 == 0, 10'((i * 61 + 9) % 1024), 10'((i * 17 + 6) % 1024), 10'((i * 23 + 4) % 1024), "R8 R9 hpf", got);
    cfg_depth = 1;
    for (int i = 0; i < 8; i++)
      px(0, i == 3, 10'((i * 11 + 1) % 1024), 10'((i * 7 + 2) % 1024), 10'((i * 5 + 3) % 1024), "R8 hpf 8bit", got);
    cfg_hpf = 0;

    // free run across frames R7
    cfg_depth = 0;
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 6; i++)
        px(i == 0, i == 0, 10'(i * 3 + 8), 10'(i * 5 + 7), 10'(i * 2 + 9), "R7 free", got);

    // reseed per frame: two frames must match R6
    cfg_frame_reseed = 1; cfg_seed = 28'h0123457;
    for (int i = 0; i < 8; i++) begin
      px(i == 0, i == 0, 10'(i * 3 + 8), 10'(i * 5 + 7), 10'(i * 2 + 9), "R6 frame a", got);
      frame_a[i] = got;
    end
    idle(2);
    for (int i = 0; i < 8; i++) begin
      px(i == 0, i == 0, 10'(i * 3 + 8), 10'(i * 5 + 7), 10'(i * 2 + 9), "R6 frame b", got);
      chk(got == frame_a[i], "R6 repeat", 32'(got[0]), 32'(frame_a[i][0]));
    end

    // zero seed behaves as seed 1 R6
    cfg_seed = 0; cfg_mode = 0;
    px(1, 1, 10'd15, 10'd15, 10'd15, "R6 zero seed", got);
    chk(got[0] == 8'd1, "R6 zero seed red", 32'(got[0]), 1);

    // saturation R3
    cfg_depth = 1;
    px(0, 0, 10'h3FF, 10'h3FE, 10'h3FD, "R3 saturate", got);
    chk(got[0] == 8'hFF, "R3 sat red", 32'(got[0]), 32'hFF);
    cfg_depth = 0;
    px(0, 0, 10'h3FF, 10'h3FF, 10'h3FF, "R3 saturate 6", got);
    chk(got[0] == 8'h3F, "R1 R3 sat 6bit", 32'(got[0]), 32'h3F);

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule